// File: doc/BRIEF.md
# Boolean Bit-Processing Unit

This block is the single-bit engine of an accumulator-style microcontroller core. It owns the carry flag and carries out every operation that acts on one bit: on the carry flag itself, or on one bit of a bit-addressable byte. Each cycle in which `opValid` is high, it accepts one operation code and one 8-bit bit address. It maps that address to a byte address and reads the byte through an asynchronous read port. It then writes the byte back in the same cycle with only the selected bit changed.

Each accepted operation produces a result one cycle later. `resValid` pulses, and `resTaken` reports the outcome of a bit test, which the program-counter logic outside the block uses to decide on a relative branch. The carry flag is a register, and `carryFlag` shows its current value. The external byte store is modelled as a plain read/write port: `memRdData` must return the byte at `memAddr` in the same cycle. A write takes effect at the clock edge while `memWrEn` is high.

Top module: `bitProc`

## Requirements
- R1: While `rstN` is low and after its release, `carryFlag` is 0 and `resValid` is 0, and `memWrEn` is 0 while `opValid` is 0.
- R2: A bit address below 0x80 selects byte 0x20 plus address bits [6:3]. A bit address of 0x80 or above selects the address with bits [2:0] cleared. In both cases address bits [2:0] give the bit position within the byte.
- R3: Opcodes 0xC3, 0xD3 and 0xB3 clear, set and invert the carry flag, and the new value appears on `carryFlag` in the cycle after the operation.
- R4: Opcodes 0xC2, 0xD2 and 0xB2 clear, set and invert the addressed bit. `memWrEn` is high in the operation cycle, and the other seven bits of `memWrData` equal the bits read.
- R5: Opcode 0x82 sets carry to carry AND the addressed bit. Opcode 0xB0 sets carry to carry AND the inverse of that bit.
- R6: Opcode 0x72 sets carry to carry OR the addressed bit. Opcode 0xA0 sets carry to carry OR the inverse of that bit.
- R7: The inverted-operand forms 0xB0 and 0xA0 never raise `memWrEn`, so the addressed byte is left unchanged.
- R8: Opcode 0xA2 copies the addressed bit into carry. Opcode 0x92 writes the carry value into the addressed bit.
- R9: Opcode 0x20 reports `resTaken`=1 when the addressed bit is 1, and opcode 0x30 reports `resTaken`=1 when it is 0. Both report one cycle after the operation, with `resValid`=1, and neither writes nor changes carry.
- R10: Opcode 0x10 reports `resTaken`=1 when the addressed bit is 1 and clears that bit in the same cycle. When the bit is 0, it reports 0 and does not write.
- R11: Any other opcode produces `resValid`=1 with `resTaken`=0 and no write. While `opValid` is low, carry holds and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 8 | Operation code |
| bitAddr | input | 8 | Bit address |
| memRdData | input | 8 | Byte read at `memAddr` (same cycle) |
| memAddr | output | 8 | Byte address of the addressed bit |
| memWrEn | output | 1 | Write the byte back at the clock edge |
| memWrData | output | 8 | Byte to write, with one bit updated |
| carryFlag | output | 1 | Current carry flag |
| resValid | output | 1 | Result of the previous cycle's operation is valid |
| resTaken | output | 1 | Bit-test outcome for the previous operation |

## Verification
On every cycle, the assertions check that:
- the byte written back differs from the byte read only at the selected position;
- both address ranges map as specified;
- the inverted-operand forms never write;
- a jump-and-clear on a set bit writes a zero;
- an idle cycle neither writes nor moves carry.

The reaction of carry to set, clear, move and test operations is also checked as a one-cycle property. Only the bench's scenarios show the combined effect of sequences: a bit set by one operation and then seen by AND, OR or a test, a second jump-and-clear finding the bit already cleared, and byte contents read back after a run of updates.

// File: rtl/bitProcPkg.sv
package bitProcPkg;

  localparam logic [7:0] OP_CLR_C    = 8'hC3;
  localparam logic [7:0] OP_SET_C    = 8'hD3;
  localparam logic [7:0] OP_CPL_C    = 8'hB3;
  localparam logic [7:0] OP_CLR_BIT  = 8'hC2;
  localparam logic [7:0] OP_SET_BIT  = 8'hD2;
  localparam logic [7:0] OP_CPL_BIT  = 8'hB2;
  localparam logic [7:0] OP_AND_BIT  = 8'h82;
  localparam logic [7:0] OP_AND_NBIT = 8'hB0;
  localparam logic [7:0] OP_OR_BIT   = 8'h72;
  localparam logic [7:0] OP_OR_NBIT  = 8'hA0;
  localparam logic [7:0] OP_LOAD_C   = 8'hA2;
  localparam logic [7:0] OP_STORE_C  = 8'h92;
  localparam logic [7:0] OP_TEST_SET = 8'h20;
  localparam logic [7:0] OP_TEST_CLR = 8'h30;
  localparam logic [7:0] OP_TEST_TAKE = 8'h10;

  typedef enum logic [2:0] {
    C_KEEP, C_CLR, C_SET, C_CPL, C_AND, C_OR, C_LOAD
  } carryOpE;

  typedef enum logic [2:0] {
    B_NONE, B_CLR, B_SET, B_CPL, B_STORE, B_CLR_IF_SET
  } bitOpE;

  typedef enum logic [1:0] {
    T_NONE, T_IF_SET, T_IF_CLR
  } testOpE;

  typedef struct packed {
    carryOpE carryOp;
    bitOpE   bitOp;
    testOpE  testOp;
    logic    invOperand;
  } strobeT;

endpackage

// File: rtl/bitCtrl.sv
module bitCtrl
  import bitProcPkg::*;
(
  input  logic       opValid,
  input  logic [7:0] opCode,
  output strobeT     strb
);

  always_comb begin
    strb.carryOp    = C_KEEP;
    strb.bitOp      = B_NONE;
    strb.testOp     = T_NONE;
    strb.invOperand = 1'b0;
    if (opValid) begin
      unique case (opCode)
        OP_CLR_C:     strb.carryOp = C_CLR;
        OP_SET_C:     strb.carryOp = C_SET;
        OP_CPL_C:     strb.carryOp = C_CPL;
        OP_CLR_BIT:   strb.bitOp   = B_CLR;
        OP_SET_BIT:   strb.bitOp   = B_SET;
        OP_CPL_BIT:   strb.bitOp   = B_CPL;
        OP_AND_BIT:   strb.carryOp = C_AND;
        OP_AND_NBIT: begin
          strb.carryOp    = C_AND;
          strb.invOperand = 1'b1;
        end
        OP_OR_BIT:    strb.carryOp = C_OR;
        OP_OR_NBIT: begin
          strb.carryOp    = C_OR;
          strb.invOperand = 1'b1;
        end
        OP_LOAD_C:    strb.carryOp = C_LOAD;
        OP_STORE_C:   strb.bitOp   = B_STORE;
        OP_TEST_SET:  strb.testOp  = T_IF_SET;
        OP_TEST_CLR:  strb.testOp  = T_IF_CLR;
        OP_TEST_TAKE: begin
          strb.testOp = T_IF_SET;
          strb.bitOp  = B_CLR_IF_SET;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bitDatapath.sv
module bitDatapath
  import bitProcPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_ADDR_W = 8,
  parameter logic [BIT_ADDR_W-1:0] LOW_BASE = 8'h20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  strobeT                strb,
  input  logic [BIT_ADDR_W-1:0] bitAddr,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [BIT_ADDR_W-1:0] memAddr,
  output logic                  memWrEn,
  output logic [DATA_W-1:0]     memWrData,
  output logic                  carryFlag,
  output logic                  resValid,
  output logic                  resTaken
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int GRP_W = BIT_ADDR_W - 1 - IDX_W;

  logic [IDX_W-1:0] bitIdx;
  logic             curBit;
  logic             operand;
  logic             newBit;
  logic             carryNext;
  logic             takenNow;

  assign bitIdx = bitAddr[IDX_W-1:0];

  // Lower half addresses a packed group of bytes; upper half addresses
  // bytes whose address is a multiple of DATA_W.
  always_comb begin
    if (bitAddr[BIT_ADDR_W-1])
      memAddr = {bitAddr[BIT_ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
    else
      memAddr = LOW_BASE + BIT_ADDR_W'(bitAddr[IDX_W +: GRP_W]);
  end

  assign curBit  = memRdData[bitIdx];
  assign operand = curBit ^ strb.invOperand;

  always_comb begin
    unique case (strb.carryOp)
      C_CLR:   carryNext = 1'b0;
      C_SET:   carryNext = 1'b1;
      C_CPL:   carryNext = ~carryFlag;
      C_AND:   carryNext = carryFlag & operand;
      C_OR:    carryNext = carryFlag | operand;
      C_LOAD:  carryNext = curBit;
      default: carryNext = carryFlag;
    endcase
  end

  always_comb begin
    unique case (strb.bitOp)
      B_SET:   newBit = 1'b1;
      B_CPL:   newBit = ~curBit;
      B_STORE: newBit = carryFlag;
      default: newBit = 1'b0;
    endcase
  end

  assign memWrEn = (strb.bitOp != B_NONE) &&
                   ((strb.bitOp != B_CLR_IF_SET) || curBit);

  for (genvar g = 0; g < DATA_W; g++) begin : gMerge
    assign memWrData[g] = (bitIdx == IDX_W'(g)) ? newBit : memRdData[g];
  end

  always_comb begin
    unique case (strb.testOp)
      T_IF_SET: takenNow = curBit;
      T_IF_CLR: takenNow = ~curBit;
      default:  takenNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      resValid  <= 1'b0;
      resTaken  <= 1'b0;
    end else begin
      carryFlag <= carryNext;
      resValid  <= opValid;
      resTaken  <= opValid & takenNow;
    end
  end

endmodule

// File: rtl/bitProc.sv
module bitProc
  import bitProcPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_ADDR_W = 8,
  parameter logic [BIT_ADDR_W-1:0] LOW_BASE = 8'h20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [7:0]            opCode,
  input  logic [BIT_ADDR_W-1:0] bitAddr,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [BIT_ADDR_W-1:0] memAddr,
  output logic                  memWrEn,
  output logic [DATA_W-1:0]     memWrData,
  output logic                  carryFlag,
  output logic                  resValid,
  output logic                  resTaken
);

  strobeT strb;

  bitCtrl ctrl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .strb    (strb)
  );

  bitDatapath #(
    .DATA_W     (DATA_W),
    .BIT_ADDR_W (BIT_ADDR_W),
    .LOW_BASE   (LOW_BASE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .strb      (strb),
    .bitAddr   (bitAddr),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .carryFlag (carryFlag),
    .resValid  (resValid),
    .resTaken  (resTaken)
  );

endmodule

// File: rtl/bitProcChk.sv
module bitProcChk #(
  parameter int DATA_W = 8,
  parameter int BIT_ADDR_W = 8,
  parameter logic [BIT_ADDR_W-1:0] LOW_BASE = 8'h20
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  opValid,
  input logic [7:0]            opCode,
  input logic [BIT_ADDR_W-1:0] bitAddr,
  input logic [DATA_W-1:0]     memRdData,
  input logic [BIT_ADDR_W-1:0] memAddr,
  input logic                  memWrEn,
  input logic [DATA_W-1:0]     memWrData,
  input logic                  carryFlag,
  input logic                  resValid,
  input logic                  resTaken
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] selMask;
  logic              selBit;
  assign selMask = DATA_W'(1) << bitAddr[IDX_W-1:0];
  assign selBit  = |(memRdData & selMask);

  p_reset_r1: assert property (@(posedge clk) !rstN |=> !carryFlag && !resValid);

  p_low_map_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !bitAddr[BIT_ADDR_W-1]) |->
      memAddr == LOW_BASE + BIT_ADDR_W'(bitAddr[BIT_ADDR_W-2:IDX_W]));

  p_high_map_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && bitAddr[BIT_ADDR_W-1]) |->
      (memAddr[IDX_W-1:0] == '0 &&
       memAddr[BIT_ADDR_W-1:IDX_W] == bitAddr[BIT_ADDR_W-1:IDX_W]));

  p_set_c_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 8'hD3) |=> carryFlag);

  p_clr_c_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 8'hC3) |=> !carryFlag);

  p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ((memWrData ^ memRdData) & ~selMask) == '0);

  p_inv_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 8'hB0 || opCode == 8'hA0)) |-> !memWrEn);

  p_load_c_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 8'hA2) |=> carryFlag == $past(selBit));

  p_test_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 8'h20) |=> resValid && resTaken == $past(selBit));

  p_take_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 8'h10 && selBit) |->
      memWrEn && (memWrData & selMask) == '0);

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !memWrEn);

  p_idle_carry_r11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(carryFlag));

endmodule

bind bitProc bitProcChk #(
  .DATA_W     (DATA_W),
  .BIT_ADDR_W (BIT_ADDR_W),
  .LOW_BASE   (LOW_BASE)
) chk_i (.*);

// File: tb/bitProc_tb_top.sv
module bitProc_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic [7:0] bitAddr = 8'h00;
  logic [7:0] memRdData;
  logic [7:0] memAddr;
  logic       memWrEn;
  logic [7:0] memWrData;
  logic       carryFlag;
  logic       resValid;
  logic       resTaken;

  logic [7:0] mem    [256];
  logic [7:0] refMem [256];
  logic       refCarry = 1'b0;

  logic  expTaken [$];
  logic  expCarry [$];
  string expTag   [$];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bitProc dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .bitAddr(bitAddr), .memRdData(memRdData), .memAddr(memAddr),
    .memWrEn(memWrEn), .memWrData(memWrData), .carryFlag(carryFlag),
    .resValid(resValid), .resTaken(resTaken)
  );

  assign memRdData = mem[memAddr];
  always @(posedge clk) if (memWrEn) mem[memAddr] <= memWrData;

  function automatic logic [7:0] mapAddr(input logic [7:0] a);
    return a[7] ? {a[7:3], 3'b000} : 8'h20 + {4'h0, a[6:3]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one operation and pushes the expected result.
  task automatic issue(input logic [7:0] op, input logic [7:0] a, input string tag);
    logic [7:0] byteA;
    logic b, nb, wr, tk, c;
    @(posedge clk); #1;
    opValid = 1'b1; opCode = op; bitAddr = a;
    byteA = mapAddr(a);
    b = refMem[byteA][a[2:0]];
    c = refCarry; nb = b; wr = 1'b0; tk = 1'b0;
    case (op)
      8'hC3: c = 1'b0;
      8'hD3: c = 1'b1;
      8'hB3: c = ~c;
      8'hC2: begin nb = 1'b0; wr = 1'b1; end
      8'hD2: begin nb = 1'b1; wr = 1'b1; end
      8'hB2: begin nb = ~b; wr = 1'b1; end
      8'h82: c = c & b;
      8'hB0: c = c & ~b;
      8'h72: c = c | b;
      8'hA0: c = c | ~b;
      8'hA2: c = b;
      8'h92: begin nb = refCarry; wr = 1'b1; end
      8'h20: tk = b;
      8'h30: tk = ~b;
      8'h10: begin tk = b; if (b) begin nb = 1'b0; wr = 1'b1; end end
      default: ;
    endcase
    if (wr) refMem[byteA][a[2:0]] = nb;
    refCarry = c;
    expTaken.push_back(tk);
    expCarry.push_back(c);
    expTag.push_back(tag);
    #1;
    check(memWrEn == wr, tag, "write enable", memWrEn, wr);
    if (wr || op == 8'hB0 || op == 8'hA0 || op == 8'h20)
      check(memAddr == byteA, tag, "byte address", memAddr, byteA);
  endtask

  task automatic checkByte(input logic [7:0] byteA, input string tag);
    @(posedge clk); #1;
    opValid = 1'b0;
    @(negedge clk);
    check(mem[byteA] == refMem[byteA], tag, "byte content", mem[byteA], refMem[byteA]);
  endtask

  // Monitor: pops the expected result whenever the design reports one.
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expTaken.size() == 0) begin
        check(1'b0, "R11", "unexpected result", 1, 0);
      end else begin
        automatic logic tk = expTaken.pop_front();
        automatic logic c  = expCarry.pop_front();
        automatic string t = expTag.pop_front();
        check(resTaken == tk, t, "taken", resTaken, tk);
        check(carryFlag == c, t, "carry", carryFlag, c);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 37 + 5);
      refMem[i] = 8'(i * 37 + 5);
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(carryFlag == 1'b0, "R1", "carry after reset", carryFlag, 0);
    check(resValid == 1'b0, "R1", "valid after reset", resValid, 0);
    check(memWrEn == 1'b0, "R1", "idle write", memWrEn, 0);

    // R3 carry operations
    issue(8'hD3, 8'h00, "R3");
    issue(8'hB3, 8'h00, "R3");
    issue(8'hB3, 8'h00, "R3");
    issue(8'hC3, 8'h00, "R3");

    // R4 bit operations, R2 mapping
    issue(8'hD2, 8'h13, "R4");
    checkByte(8'h22, "R4");
    issue(8'hC2, 8'h13, "R4");
    issue(8'hB2, 8'h13, "R4");
    checkByte(8'h22, "R4");
    issue(8'hB2, 8'hE5, "R2");
    checkByte(8'hE0, "R2");
    issue(8'hD2, 8'h7F, "R2");
    checkByte(8'h2F, "R2");
    issue(8'hC2, 8'h80, "R2");
    checkByte(8'h80, "R2");

    // R5 AND forms
    issue(8'hD2, 8'h13, "R5");
    issue(8'hD3, 8'h00, "R5");
    issue(8'h82, 8'h13, "R5");
    issue(8'hB0, 8'h13, "R5");
    issue(8'hC2, 8'h13, "R5");
    issue(8'hD3, 8'h00, "R5");
    issue(8'hB0, 8'h13, "R5");
    issue(8'h82, 8'h13, "R5");

    // R6 OR forms
    issue(8'hC3, 8'h00, "R6");
    issue(8'hD2, 8'h45, "R6");
    issue(8'h72, 8'h45, "R6");
    issue(8'hC3, 8'h00, "R6");
    issue(8'hA0, 8'h45, "R6");
    issue(8'hC2, 8'h45, "R6");
    issue(8'hA0, 8'h45, "R6");
    issue(8'hC3, 8'h00, "R6");
    issue(8'h72, 8'h45, "R6");

    // R7 inverted forms leave the byte untouched
    issue(8'hB0, 8'hC6, "R7");
    issue(8'hA0, 8'hC6, "R7");
    checkByte(8'hC0, "R7");

    // R8 moves
    issue(8'hD3, 8'h00, "R8");
    issue(8'h92, 8'h31, "R8");
    checkByte(8'h26, "R8");
    issue(8'hC3, 8'h00, "R8");
    issue(8'hA2, 8'h31, "R8");
    issue(8'hC3, 8'h00, "R8");
    issue(8'h92, 8'hF2, "R8");
    checkByte(8'hF0, "R8");

    // R9 bit tests
    issue(8'hD2, 8'h50, "R9");
    issue(8'h20, 8'h50, "R9");
    issue(8'h30, 8'h50, "R9");
    issue(8'hC2, 8'h50, "R9");
    issue(8'h20, 8'h50, "R9");
    issue(8'h30, 8'h50, "R9");

    // R10 jump-and-clear
    issue(8'hD2, 8'h0A, "R10");
    issue(8'h10, 8'h0A, "R10");
    checkByte(8'h21, "R10");
    issue(8'h10, 8'h0A, "R10");
    checkByte(8'h21, "R10");

    // R11 unknown opcodes and idle cycles
    issue(8'hD3, 8'h00, "R11");
    issue(8'hFF, 8'h13, "R11");
    issue(8'h00, 8'hE5, "R11");
    checkByte(8'h22, "R11");
    repeat (3) @(negedge clk);
    check(carryFlag == refCarry, "R11", "carry held while idle", carryFlag, refCarry);
    check(expTaken.size() == 0, "R11", "results pending", expTaken.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule